// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an operand addressing request into a 32-bit effective address. Each request carries an addressing-mode code, a base-register select, an instruction class, a prefix directive code, an I/O-space hint and up to 32 bits of operand bytes taken from the instruction. The request also carries a snapshot of the pointer registers (HL, BC, DE, IX, IY, the stack pointer and the program counter). The register file, instruction decoding and the bus cycle itself are outside the block.

The block accepts one request on any cycle where the strobe is high. It returns a registered result one cycle later, with a one-cycle valid pulse. The result holds the address and three flags: the access goes to I/O space, the mode has no address, or the request is illegal. A prefix directive widens the operand field. Direct addresses are zero-extended and displacements are sign-extended to 32 bits. Every sum wraps modulo 2^32.

Top module: `operand_ea_gen`

## Requirements
- R1: `valid_o` pulses high exactly one cycle after each cycle with `req_valid_i` high, and is low otherwise. All result outputs change only in the cycle after a request and otherwise hold their last value. All outputs are zero during reset.
- R2: Mode 0 (register) and mode 1 (immediate) give `no_addr_o`=1, `addr_o`=0, `io_o`=0 and `illegal_o`=0.
- R3: Mode 2 (indirect) with `io_space_i`=0 gives the base register picked by `sel_i`: 0=HL, 1=BC, 2=DE. The result is a memory access with `io_o`=0.
- R4: Mode 2 with `io_space_i`=1 always gives BC, whatever `sel_i` is, and sets `io_o`=1.
- R5: Mode 2 with `sel_i` 3 (IX) or 4 (IY) is legal only when `class_i`=1 (jump). For any other class it is illegal.
- R6: Mode 3 (direct) zero-extends the low 16 bits of `oper_i` when `dir_i`=0, the low 24 bits when `dir_i`=1, and all 32 bits when `dir_i`=2. In this mode `io_o` follows `io_space_i`.
- R7: Mode 4 (indexed) adds a sign-extended displacement to IX (`sel_i`=3) or IY (`sel_i`=4), wrapping modulo 2^32. The displacement is `oper_i` bits [7:0], [15:0] or [23:0] for `dir_i` 0, 1 or 2. Any other `sel_i` is illegal.
- R8: Mode 6 (stack-pointer relative) adds a displacement of the same directive-selected width to the stack pointer, wrapping modulo 2^32.
- R9: Mode 5 (PC relative) adds a displacement of the same directive-selected width to the program counter. It is legal only when `class_i` is 1 (jump) or 2 (call).
- R10: Mode 7, `dir_i`=3, and indirect `sel_i` values 5 to 7 are illegal. An illegal result has `illegal_o`=1, and `addr_o`=0, `io_o`=0 and `no_addr_o`=0. Illegality takes precedence over the no-address flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| sel_i | input | 3 | Base register select |
| class_i | input | 2 | Instruction class: 0 other, 1 jump, 2 call, 3 other |
| dir_i | input | 2 | Prefix directive: 0 none, 1 byte, 2 word, 3 reserved |
| io_space_i | input | 1 | Request targets I/O space |
| oper_i | input | 32 | Address or displacement bytes from the instruction |
| hl_i | input | 32 | HL snapshot |
| bc_i | input | 32 | BC snapshot |
| de_i | input | 32 | DE snapshot |
| ix_i | input | 32 | IX snapshot |
| iy_i | input | 32 | IY snapshot |
| sp_i | input | 32 | Stack pointer snapshot |
| pc_i | input | 32 | Program counter snapshot |
| valid_o | output | 1 | Result valid pulse |
| addr_o | output | 32 | Effective address |
| io_o | output | 1 | Address is in I/O space |
| no_addr_o | output | 1 | Mode has no effective address |
| illegal_o | output | 1 | Request is illegal |

## Verification
Two conditions can arise in the same request. A reserved directive or a forbidden mode/class pairing is an illegality. A register or immediate mode is a no-address case. Both can land in one request, and so can an I/O-space hint with an illegal base. The bench provokes these overlaps with directed requests, for example a register mode under a reserved directive, and with thousands of random requests over every code. Each cycle it compares the outputs with a behavioural model in which illegality wins and clears the address, the I/O flag and the no-address flag.

// File: rtl/operand_ea_pkg.sv
package operand_ea_pkg;
  localparam int AW = 32;

  typedef enum logic [2:0] {
    M_REG = 3'd0,
    M_IMM = 3'd1,
    M_IND = 3'd2,
    M_DIR = 3'd3,
    M_IDX = 3'd4,
    M_PCR = 3'd5,
    M_SPR = 3'd6,
    M_RSV = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    D_NONE = 2'd0,
    D_BYTE = 2'd1,
    D_WORD = 2'd2,
    D_RSV  = 2'd3
  } dir_e;

  typedef enum logic [1:0] {
    C_OTHER = 2'd0,
    C_JUMP  = 2'd1,
    C_CALL  = 2'd2,
    C_MISC  = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    B_HL = 3'd0,
    B_BC = 3'd1,
    B_DE = 3'd2,
    B_IX = 3'd3,
    B_IY = 3'd4
  } base_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          io;
    logic          no_addr;
    logic          illegal;
  } ea_res_t;
endpackage

// File: rtl/operand_ea_ext.sv
// Widens the operand field per directive: sign-extended displacement and zero-extended address.
module operand_ea_ext #(
  parameter int AW  = 32,
  parameter int DW0 = 8,
  parameter int DW1 = 16,
  parameter int DW2 = 24,
  parameter int ZW0 = 16,
  parameter int ZW1 = 24,
  parameter int ZW2 = 32
) (
  input  logic [1:0]    dir_i,
  input  logic [AW-1:0] raw_i,
  output logic [AW-1:0] disp_o,
  output logic [AW-1:0] abs_o,
  output logic          bad_o
);
  import operand_ea_pkg::*;

  localparam int NLVL = 3;

  function automatic int sw_of(input int k);
    case (k)
      0:       return DW0;
      1:       return DW1;
      default: return DW2;
    endcase
  endfunction

  function automatic int zw_of(input int k);
    case (k)
      0:       return ZW0;
      1:       return ZW1;
      default: return ZW2;
    endcase
  endfunction

  logic [AW-1:0] sx [NLVL];
  logic [AW-1:0] zx [NLVL];

  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    localparam int SW = sw_of(k);
    localparam int ZW = zw_of(k);
    if (SW < AW) begin : g_sx
      assign sx[k] = {{(AW-SW){raw_i[SW-1]}}, raw_i[SW-1:0]};
    end else begin : g_sx_full
      assign sx[k] = raw_i;
    end
    if (ZW < AW) begin : g_zx
      assign zx[k] = {{(AW-ZW){1'b0}}, raw_i[ZW-1:0]};
    end else begin : g_zx_full
      assign zx[k] = raw_i;
    end
  end

  always_comb begin
    bad_o  = 1'b0;
    disp_o = '0;
    abs_o  = '0;
    unique case (dir_e'(dir_i))
      D_NONE: begin disp_o = sx[0]; abs_o = zx[0]; end
      D_BYTE: begin disp_o = sx[1]; abs_o = zx[1]; end
      D_WORD: begin disp_o = sx[2]; abs_o = zx[2]; end
      D_RSV:  bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/operand_ea_base.sv
// Base register selection and per-mode legality.
module operand_ea_base #(
  parameter int AW = 32
) (
  input  logic [2:0]    mode_i,
  input  logic [2:0]    sel_i,
  input  logic [1:0]    class_i,
  input  logic          io_space_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] bc_i,
  input  logic [AW-1:0] de_i,
  input  logic [AW-1:0] ix_i,
  input  logic [AW-1:0] iy_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] base_o,
  output logic          bad_o,
  output logic          io_o
);
  import operand_ea_pkg::*;

  cls_e  cls;
  logic  is_jump;
  logic  is_branch;

  assign cls       = cls_e'(class_i);
  assign is_jump   = (cls == C_JUMP);
  assign is_branch = (cls == C_JUMP) || (cls == C_CALL);

  always_comb begin
    base_o = '0;
    bad_o  = 1'b0;
    io_o   = 1'b0;
    unique case (mode_e'(mode_i))
      M_IND: begin
        if (io_space_i) begin
          base_o = bc_i;   // I/O indirect is always through BC
          io_o   = 1'b1;
        end else begin
          case (sel_i)
            B_HL:    base_o = hl_i;
            B_BC:    base_o = bc_i;
            B_DE:    base_o = de_i;
            B_IX:    begin base_o = ix_i; bad_o = !is_jump; end
            B_IY:    begin base_o = iy_i; bad_o = !is_jump; end
            default: bad_o = 1'b1;
          endcase
        end
      end
      M_DIR: io_o = io_space_i;
      M_IDX: begin
        case (sel_i)
          B_IX:    base_o = ix_i;
          B_IY:    base_o = iy_i;
          default: bad_o = 1'b1;
        endcase
      end
      M_PCR: begin
        base_o = pc_i;
        bad_o  = !is_branch;
      end
      M_SPR: base_o = sp_i;
      M_RSV: bad_o = 1'b1;
      M_REG, M_IMM: ;
    endcase
  end
endmodule

// File: rtl/operand_ea_gen.sv
module operand_ea_gen #(
  parameter int AW = operand_ea_pkg::AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    sel_i,
  input  logic [1:0]    class_i,
  input  logic [1:0]    dir_i,
  input  logic          io_space_i,
  input  logic [AW-1:0] oper_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] bc_i,
  input  logic [AW-1:0] de_i,
  input  logic [AW-1:0] ix_i,
  input  logic [AW-1:0] iy_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          io_o,
  output logic          no_addr_o,
  output logic          illegal_o
);
  import operand_ea_pkg::*;

  logic [AW-1:0] disp, absa, base;
  logic          dir_bad, base_bad, base_io;
  ea_res_t       res_d, res_q;
  logic          valid_q;

  operand_ea_ext #(.AW(AW)) u_ext (
    .dir_i  (dir_i),
    .raw_i  (oper_i),
    .disp_o (disp),
    .abs_o  (absa),
    .bad_o  (dir_bad)
  );

  operand_ea_base #(.AW(AW)) u_base (
    .mode_i     (mode_i),
    .sel_i      (sel_i),
    .class_i    (class_i),
    .io_space_i (io_space_i),
    .hl_i       (hl_i),
    .bc_i       (bc_i),
    .de_i       (de_i),
    .ix_i       (ix_i),
    .iy_i       (iy_i),
    .sp_i       (sp_i),
    .pc_i       (pc_i),
    .base_o     (base),
    .bad_o      (base_bad),
    .io_o       (base_io)
  );

  always_comb begin
    res_d = '0;
    unique case (mode_e'(mode_i))
      M_REG, M_IMM:        res_d.no_addr = 1'b1;
      M_IND:               res_d.addr = base;
      M_DIR:               res_d.addr = absa;
      M_IDX, M_PCR, M_SPR: res_d.addr = base + disp;
      M_RSV:               ;
    endcase
    res_d.io = base_io;
    // illegality overrides everything else
    if (dir_bad || base_bad) begin
      res_d         = '0;
      res_d.illegal = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) res_q <= res_d;
    end
  end

  assign valid_o   = valid_q;
  assign addr_o    = res_q.addr;
  assign io_o      = res_q.io;
  assign no_addr_o = res_q.no_addr;
  assign illegal_o = res_q.illegal;
endmodule

// File: rtl/operand_ea_gen_chk.sv
module operand_ea_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [2:0]    mode_i,
  input logic [2:0]    sel_i,
  input logic [1:0]    class_i,
  input logic [1:0]    dir_i,
  input logic          io_space_i,
  input logic [AW-1:0] bc_i,
  input logic          valid_o,
  input logic [AW-1:0] addr_o,
  input logic          io_o,
  input logic          no_addr_o,
  input logic          illegal_o
);
  logic req_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_seen_q <= 1'b0;
    else         req_seen_q <= req_valid_i;
  end

  assert_valid_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == req_seen_q);

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(addr_o) && $stable(io_o) && $stable(no_addr_o) && $stable(illegal_o)));

  assert_no_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && no_addr_o) |-> (addr_o == '0 && !io_o && !illegal_o));

  assert_io_bc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 3'd2 && io_space_i && dir_i != 2'd3)
      |=> (io_o && !illegal_o && addr_o == $past(bc_i)));

  assert_ixiy_class_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 3'd2 && !io_space_i && (sel_i == 3'd3 || sel_i == 3'd4) && class_i != 2'd1)
      |=> illegal_o);

  assert_pcrel_class_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 3'd5 && (class_i == 2'd0 || class_i == 2'd3)) |=> illegal_o);

  assert_rsv_dir_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dir_i == 2'd3) |=> (valid_o && illegal_o));

  assert_illegal_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (addr_o == '0 && !io_o && !no_addr_o));
endmodule

bind operand_ea_gen operand_ea_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/operand_ea_gen_test.sv
module operand_ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0, sel = '0;
  logic [1:0]  cls = '0, dir = '0;
  logic        ios = 1'b0;
  logic [31:0] oper = '0, hl = '0, bc = '0, de = '0, ix = '0, iy = '0, sp = '0, pc = '0;
  logic        valid_o, io_o, no_addr_o, illegal_o;
  logic [31:0] addr_o;

  always #2 clk = ~clk;

  operand_ea_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .mode_i(mode), .sel_i(sel),
    .class_i(cls), .dir_i(dir), .io_space_i(ios), .oper_i(oper),
    .hl_i(hl), .bc_i(bc), .de_i(de), .ix_i(ix), .iy_i(iy), .sp_i(sp), .pc_i(pc),
    .valid_o(valid_o), .addr_o(addr_o), .io_o(io_o), .no_addr_o(no_addr_o), .illegal_o(illegal_o)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;

  bit          e_v = 0, e_io = 0, e_na = 0, e_il = 0;
  logic [31:0] e_a = '0;
  string       e_tag = "R1";

  function automatic void ref_ea(
    input  logic [2:0] mo, input logic [2:0] s, input logic [1:0] c, input logic [1:0] d,
    input  bit io, input logic [31:0] op,
    output logic [31:0] a, output bit o_io, output bit o_na, output bit o_il, output string tag);
    logic [31:0] sx, zx;
    bit dbad, bad;
    dbad = 0; bad = 0; sx = 0; zx = 0;
    a = 0; o_io = 0; o_na = 0; o_il = 0; tag = "R1";
    case (d)
      2'd0: begin sx = {{24{op[7]}},  op[7:0]};  zx = {16'h0, op[15:0]}; end
      2'd1: begin sx = {{16{op[15]}}, op[15:0]}; zx = {8'h0,  op[23:0]}; end
      2'd2: begin sx = {{8{op[23]}},  op[23:0]}; zx = op; end
      default: dbad = 1;
    endcase
    case (mo)
      3'd0, 3'd1: begin o_na = 1; tag = "R2"; end
      3'd2: begin
        if (io) begin a = bc; o_io = 1; tag = "R4"; end
        else begin
          case (s)
            3'd0: begin a = hl; tag = "R3"; end
            3'd1: begin a = bc; tag = "R3"; end
            3'd2: begin a = de; tag = "R3"; end
            3'd3: begin a = ix; bad = (c != 2'd1); tag = "R5"; end
            3'd4: begin a = iy; bad = (c != 2'd1); tag = "R5"; end
            default: begin bad = 1; tag = "R10"; end
          endcase
        end
      end
      3'd3: begin a = zx; o_io = io; tag = "R6"; end
      3'd4: begin
        tag = "R7";
        if (s == 3'd3) a = ix + sx;
        else if (s == 3'd4) a = iy + sx;
        else bad = 1;
      end
      3'd5: begin a = pc + sx; bad = !(c == 2'd1 || c == 2'd2); tag = "R9"; end
      3'd6: begin a = sp + sx; tag = "R8"; end
      default: begin bad = 1; tag = "R10"; end
    endcase
    if (dbad) tag = "R10";
    if (dbad || bad) begin a = 0; o_io = 0; o_na = 0; o_il = 1; end
  endfunction

  task automatic compare();
    checks++;
    if (valid_o !== e_v || addr_o !== e_a || io_o !== e_io || no_addr_o !== e_na || illegal_o !== e_il) begin
      errors++;
      $display("FAIL %s: got v=%0b a=%h io=%0b na=%0b il=%0b, expected v=%0b a=%h io=%0b na=%0b il=%0b",
               e_tag, valid_o, addr_o, io_o, no_addr_o, illegal_o, e_v, e_a, e_io, e_na, e_il);
    end
  endtask

  // one clock: drive at negedge, compare just after the next posedge
  task automatic step(input bit v, input logic [2:0] mo, input logic [2:0] s, input logic [1:0] c,
                      input logic [1:0] d, input bit io, input logic [31:0] op);
    @(negedge clk);
    req = v; mode = mo; sel = s; cls = c; dir = d; ios = io; oper = op;
    if (v) begin
      e_v = 1;
      ref_ea(mo, s, c, d, io, op, e_a, e_io, e_na, e_il, e_tag);
    end else begin
      e_v = 0;
      e_tag = "R1";
    end
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic rand_regs();
    hl = $urandom; bc = $urandom; de = $urandom; ix = $urandom;
    iy = $urandom; sp = $urandom; pc = $urandom;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    // reset state R1
    repeat (3) @(posedge clk);
    #1;
    e_tag = "R1"; compare();
    @(negedge clk); rst_n = 1'b1;

    hl = 32'h0000_1234; bc = 32'h0000_00BC; de = 32'h0000_0DE0;
    ix = 32'hFFFF_FFF0; iy = 32'h0000_8000; sp = 32'h0001_0000; pc = 32'h0000_0100;

    step(1, 3'd0, 3'd0, 2'd0, 2'd0, 0, 32'hDEAD_BEEF);      // R2 register
    step(1, 3'd1, 3'd0, 2'd0, 2'd1, 1, 32'h1);              // R2 immediate
    step(1, 3'd2, 3'd0, 2'd0, 2'd0, 0, 32'h0);              // R3 HL
    step(1, 3'd2, 3'd2, 2'd0, 2'd0, 0, 32'h0);              // R3 DE
    step(1, 3'd2, 3'd2, 2'd0, 2'd0, 1, 32'h0);              // R4 BC forced
    step(1, 3'd2, 3'd3, 2'd1, 2'd0, 0, 32'h0);              // R5 IX on jump
    step(1, 3'd2, 3'd4, 2'd2, 2'd0, 0, 32'h0);              // R5 IY on call -> illegal
    step(1, 3'd3, 3'd0, 2'd0, 2'd0, 0, 32'hAABB_CCDD);      // R6 16 bit
    step(1, 3'd3, 3'd0, 2'd0, 2'd1, 1, 32'hAABB_CCDD);      // R6 24 bit I/O
    step(1, 3'd3, 3'd0, 2'd0, 2'd2, 0, 32'hAABB_CCDD);      // R6 32 bit
    step(1, 3'd4, 3'd3, 2'd0, 2'd0, 0, 32'h0000_0020);      // R7 IX wrap
    step(1, 3'd4, 3'd4, 2'd0, 2'd1, 0, 32'h0000_8001);      // R7 IY negative 16 bit
    step(1, 3'd4, 3'd4, 2'd0, 2'd2, 0, 32'h00FF_FFFF);      // R7 24 bit -1
    step(1, 3'd4, 3'd1, 2'd0, 2'd0, 0, 32'h0);              // R7 bad select
    step(1, 3'd6, 3'd0, 2'd0, 2'd0, 0, 32'h0000_0080);      // R8 -128
    step(1, 3'd6, 3'd0, 2'd0, 2'd2, 0, 32'h0080_0000);      // R8 24 bit min
    step(1, 3'd5, 3'd0, 2'd1, 2'd0, 0, 32'h0000_00FE);      // R9 jump
    step(1, 3'd5, 3'd0, 2'd2, 2'd1, 0, 32'h0000_7FFF);      // R9 call
    step(1, 3'd5, 3'd0, 2'd0, 2'd0, 0, 32'h0000_0004);      // R9 other -> illegal
    step(1, 3'd0, 3'd0, 2'd0, 2'd3, 0, 32'h0);              // R10 precedence over R2
    step(1, 3'd2, 3'd0, 2'd0, 2'd3, 1, 32'h0);              // R10 reserved dir with I/O
    step(1, 3'd7, 3'd0, 2'd1, 2'd0, 0, 32'h0);              // R10 reserved mode
    step(1, 3'd2, 3'd6, 2'd1, 2'd0, 0, 32'h0);              // R10 reserved select
    step(0, 3'd3, 3'd0, 2'd0, 2'd2, 1, 32'h1234_5678);      // R1 hold, ignored
    step(0, 3'd0, 3'd0, 2'd0, 2'd0, 0, 32'h0);              // R1 hold
    step(1, 3'd6, 3'd0, 2'd0, 2'd0, 0, 32'h0000_0001);      // back-to-back
    step(1, 3'd6, 3'd0, 2'd0, 2'd0, 0, 32'h0000_0002);

    for (int i = 0; i < 4000; i++) begin
      bit v;
      rand_regs();
      v = ($urandom_range(0, 3) != 0);
      step(v, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule